// File: doc/BRIEF.md
# Interrupt flag and enable controller

This block gathers the interrupt conditions of a peripheral interface unit into one request line. Seven source flags are held in sticky latches. Each flag is set by a one-cycle pulse from its source logic: the two timers, the shift register, or one of the four control-line edge detectors. A flag is cleared in one of two ways. Other logic can send a one-cycle clear pulse when an access with a clearing side effect happens, or the host can write a one to the flag's bit in the flag register.

A seven-bit enable mask selects which flags may raise the request. The host changes the mask with a single write. Bits 6:0 of the written byte pick which enables to touch, and bit 7 says whether they are set or cleared, so no read-modify-write sequence is needed. The active-low request output is low whenever at least one flag is both latched and enabled. The flag register read returns the same condition as a summary in bit 7.

The read port is registered. `rd_data` shows the register at the address presented in the previous cycle, including any update made at that clock edge. The request output is registered at the same time as the flags, so a set pulse takes effect on both in the same cycle.

Top module: `irq_ctl`

## Requirements
- R1: A synchronous active-high reset clears all seven flags and all seven enables, drives `irq_n` to 1 and drives `rd_data` to 0.
- R2: A 1 on `src_set[i]` latches flag i at the next clock edge, and the flag stays set until it is cleared. The bit mapping is: 0 CA2-style edge, 1 CA1-style edge, 2 eight shifts done, 3 CB2-style edge, 4 CB1-style edge, 5 second timer timeout, 6 first timer timeout.
- R3: A 1 on `src_clr[i]` clears flag i at the next clock edge and leaves the other flags unchanged.
- R4: A write to offset 13 clears every flag whose data bit (6:0) is 1 and leaves the rest unchanged. Data bit 7 of that write has no effect.
- R5: When a set pulse and a clear (pulse or register write) hit the same flag in the same cycle, the flag ends up set.
- R6: A write to offset 14 changes only the enables whose data bits 6:0 are 1. They become 1 when data bit 7 is 1, and 0 when data bit 7 is 0.
- R7: A read of offset 13 returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag is set whose enable is also set.
- R8: A read of offset 14 returns 1 in bit 7 and the enable mask in bits 6:0.
- R9: `irq_n` is 0 exactly when some flag and its enable are both 1. It changes at the same clock edge as the flag and enable state.
- R10: A write to any offset other than 13 or 14 changes neither flags nor enables, and a read of such an offset returns 0.
- R11: `rd_data` is registered. One cycle after an address is presented, it shows that register's contents including any update made at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | ADDR_W | Register offset for read and write |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | DATA_W | Write data |
| src_set | input | NUM_SRC | One-cycle set pulses, one per source |
| src_clr | input | NUM_SRC | One-cycle clear pulses from side-effect accesses |
| rd_data | output | DATA_W | Registered read data for the previous cycle's address |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is a collision: in one cycle a flag receives its set pulse and is also cleared, either by a clear pulse or by a flag-register write that has a one in that flag's bit. Only these stimuli show whether set priority holds. The stimulus table drives both kinds of collision directly. In one write it clears a neighbouring flag along with the colliding one, so a single read exposes a wrong priority and an over-broad clear together. A further directed step applies reset while an enabled flag is pending, which confirms that the request output and the read port both fall back to their idle values.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned DEF_NUM_SRC  = 7;
  localparam int unsigned DEF_ADDR_W   = 4;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_FLAG_OFS = 13;
  localparam int unsigned DEF_MASK_OFS = 14;

  // source index assignment, consumed by neighbouring source logic
  localparam int unsigned SRC_CA2   = 0;
  localparam int unsigned SRC_CA1   = 1;
  localparam int unsigned SRC_SHIFT = 2;
  localparam int unsigned SRC_CB2   = 3;
  localparam int unsigned SRC_CB1   = 4;
  localparam int unsigned SRC_TMR2  = 5;
  localparam int unsigned SRC_TMR1  = 6;
endpackage

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode #(
  parameter int unsigned NUM_SRC  = irq_ctl_pkg::DEF_NUM_SRC,
  parameter int unsigned ADDR_W   = irq_ctl_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W   = irq_ctl_pkg::DEF_DATA_W,
  parameter int unsigned FLAG_OFS = irq_ctl_pkg::DEF_FLAG_OFS,
  parameter int unsigned MASK_OFS = irq_ctl_pkg::DEF_MASK_OFS
) (
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [NUM_SRC-1:0] flag_wr_clr,
  output logic [NUM_SRC-1:0] mask_sel,
  output logic               mask_val
);
  localparam int unsigned TOP_BIT = DATA_W - 1;

  logic hit_flag;
  logic hit_mask;

  always_comb begin
    hit_flag = reg_wr && (reg_addr == ADDR_W'(FLAG_OFS));
    hit_mask = reg_wr && (reg_addr == ADDR_W'(MASK_OFS));
  end

  always_comb begin
    flag_wr_clr = hit_flag ? reg_wdata[NUM_SRC-1:0] : '0;
    mask_sel    = hit_mask ? reg_wdata[NUM_SRC-1:0] : '0;
    mask_val    = reg_wdata[TOP_BIT];
  end
endmodule

// File: rtl/irq_ctl_flag_bank.sv
module irq_ctl_flag_bank #(
  parameter int unsigned NUM_SRC = irq_ctl_pkg::DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  input  logic [NUM_SRC-1:0] wr_clr,
  output logic [NUM_SRC-1:0] flag_q,
  output logic [NUM_SRC-1:0] flag_d
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    logic drop;

    always_comb begin
      drop      = src_clr[i] | wr_clr[i];
      // set has priority over either clear path
      flag_d[i] = src_set[i] | (flag_q[i] & ~drop);
    end

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/irq_ctl_mask.sv
module irq_ctl_mask #(
  parameter int unsigned NUM_SRC = irq_ctl_pkg::DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] sel,
  input  logic               val,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_d
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb begin
      en_d[i] = sel[i] ? val : en_q[i];
    end

    always_ff @(posedge clk) begin
      if (rst) en_q[i] <= 1'b0;
      else     en_q[i] <= en_d[i];
    end
  end
endmodule

// File: rtl/irq_ctl_readout.sv
module irq_ctl_readout #(
  parameter int unsigned NUM_SRC  = irq_ctl_pkg::DEF_NUM_SRC,
  parameter int unsigned ADDR_W   = irq_ctl_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W   = irq_ctl_pkg::DEF_DATA_W,
  parameter int unsigned FLAG_OFS = irq_ctl_pkg::DEF_FLAG_OFS,
  parameter int unsigned MASK_OFS = irq_ctl_pkg::DEF_MASK_OFS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] flag_d,
  input  logic [NUM_SRC-1:0] en_d,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_n
);
  localparam int unsigned TOP_BIT = DATA_W - 1;

  logic              pend_d;
  logic [DATA_W-1:0] flag_word;
  logic [DATA_W-1:0] mask_word;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    pend_d = |(flag_d & en_d);

    flag_word                = '0;
    flag_word[NUM_SRC-1:0]   = flag_d;
    flag_word[TOP_BIT]       = pend_d;

    mask_word                = '0;
    mask_word[NUM_SRC-1:0]   = en_d;
    mask_word[TOP_BIT]       = 1'b1;

    if (reg_addr == ADDR_W'(FLAG_OFS))      rd_d = flag_word;
    else if (reg_addr == ADDR_W'(MASK_OFS)) rd_d = mask_word;
    else                                    rd_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_n   <= 1'b1;
    end else begin
      rd_data <= rd_d;
      irq_n   <= ~pend_d;
    end
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int unsigned NUM_SRC  = irq_ctl_pkg::DEF_NUM_SRC,
  parameter int unsigned ADDR_W   = irq_ctl_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W   = irq_ctl_pkg::DEF_DATA_W,
  parameter int unsigned FLAG_OFS = irq_ctl_pkg::DEF_FLAG_OFS,
  parameter int unsigned MASK_OFS = irq_ctl_pkg::DEF_MASK_OFS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic [NUM_SRC-1:0] src_clr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_n
);
  logic [NUM_SRC-1:0] flag_wr_clr;
  logic [NUM_SRC-1:0] mask_sel;
  logic               mask_val;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_d;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] en_d;

  irq_ctl_decode #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FLAG_OFS(FLAG_OFS), .MASK_OFS(MASK_OFS)
  ) u_decode (
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .flag_wr_clr (flag_wr_clr),
    .mask_sel    (mask_sel),
    .mask_val    (mask_val)
  );

  irq_ctl_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .src_set (src_set),
    .src_clr (src_clr),
    .wr_clr  (flag_wr_clr),
    .flag_q  (flag_q),
    .flag_d  (flag_d)
  );

  irq_ctl_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk  (clk),
    .rst  (rst),
    .sel  (mask_sel),
    .val  (mask_val),
    .en_q (en_q),
    .en_d (en_d)
  );

  irq_ctl_readout #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FLAG_OFS(FLAG_OFS), .MASK_OFS(MASK_OFS)
  ) u_read (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .flag_d   (flag_d),
    .en_d     (en_d),
    .rd_data  (rd_data),
    .irq_n    (irq_n)
  );
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int unsigned NUM_SRC  = irq_ctl_pkg::DEF_NUM_SRC,
  parameter int unsigned ADDR_W   = irq_ctl_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W   = irq_ctl_pkg::DEF_DATA_W,
  parameter int unsigned FLAG_OFS = irq_ctl_pkg::DEF_FLAG_OFS,
  parameter int unsigned MASK_OFS = irq_ctl_pkg::DEF_MASK_OFS
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [NUM_SRC-1:0] src_set,
  input logic [NUM_SRC-1:0] src_clr,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq_n,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] en_q
);
  logic               wr_f;
  logic               wr_m;
  logic [NUM_SRC-1:0] any_clr;

  always_comb begin
    wr_f    = reg_wr && (reg_addr == ADDR_W'(FLAG_OFS));
    wr_m    = reg_wr && (reg_addr == ADDR_W'(MASK_OFS));
    any_clr = src_clr | (wr_f ? reg_wdata[NUM_SRC-1:0] : '0);
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set))); // R5

  AST_FLAG_DROP_CAUSED: assert property (@(posedge clk) disable iff (rst)
    (flag_q != '0) |=> ((~flag_q & $past(flag_q) & ~$past(any_clr)) == '0)); // R3

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_m |=> ((en_q & $past(reg_wdata[NUM_SRC-1:0])) ==
              ($past(reg_wdata[DATA_W-1]) ? $past(reg_wdata[NUM_SRC-1:0]) : '0))); // R6

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_m |=> $stable(en_q)); // R10

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq_n == ~|(flag_q & en_q))); // R9

  AST_MASK_READ_TOP: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(MASK_OFS)) |=> rd_data[DATA_W-1]); // R8
endmodule

bind irq_ctl irq_ctl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .FLAG_OFS(FLAG_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .src_set   (src_set),
  .src_clr   (src_clr),
  .rd_data   (rd_data),
  .irq_n     (irq_n),
  .flag_q    (flag_q),
  .en_q      (en_q)
);

// File: tb/irq_ctl_tb.sv
module irq_ctl_tb;
  localparam int NV = 17;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] reg_addr = 4'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [6:0] src_set = 7'h00;
  logic [6:0] src_clr = 7'h00;
  logic [7:0] rd_data;
  logic       irq_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ctl u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .src_set(src_set), .src_clr(src_clr),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  // {wr, addr, wdata, set, clr, exp_rd, exp_irq_n}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 4'd13, 8'h00, 7'h00, 7'h00, 8'h00, 1'b1},
    {1'b0, 4'd13, 8'h00, 7'h41, 7'h00, 8'h41, 1'b1},
    {1'b0, 4'd13, 8'h00, 7'h00, 7'h00, 8'h41, 1'b1},
    {1'b1, 4'd14, 8'h81, 7'h00, 7'h00, 8'h81, 1'b0},
    {1'b0, 4'd13, 8'h00, 7'h00, 7'h00, 8'hC1, 1'b0},
    {1'b1, 4'd13, 8'h01, 7'h00, 7'h00, 8'h40, 1'b1},
    {1'b1, 4'd14, 8'hC2, 7'h00, 7'h00, 8'hC3, 1'b0},
    {1'b1, 4'd14, 8'h03, 7'h00, 7'h00, 8'hC0, 1'b0},
    {1'b0, 4'd13, 8'h00, 7'h00, 7'h40, 8'h00, 1'b1},
    {1'b0, 4'd13, 8'h00, 7'h04, 7'h04, 8'h04, 1'b1},
    {1'b1, 4'd13, 8'h0C, 7'h08, 7'h00, 8'h08, 1'b1},
    {1'b1, 4'd13, 8'h80, 7'h00, 7'h00, 8'h08, 1'b1},
    {1'b1, 4'd5,  8'hFF, 7'h00, 7'h00, 8'h00, 1'b1},
    {1'b0, 4'd14, 8'h00, 7'h00, 7'h00, 8'hC0, 1'b1},
    {1'b0, 4'd13, 8'h00, 7'h40, 7'h00, 8'hC8, 1'b0},
    {1'b1, 4'd14, 8'h7F, 7'h00, 7'h00, 8'h80, 1'b1},
    {1'b0, 4'd13, 8'h00, 7'h00, 7'h00, 8'h48, 1'b1}
  };

  string vtag [NV] = '{
    "R7 idle",              "R2 set timers/CA2",  "R2 flags hold",
    "R6 R8 R9 enable set",  "R7 R11 summary",     "R4 write clears",
    "R6 enable set more",   "R6 enable clear",    "R3 clear pulse",
    "R5 set beats pulse",   "R5 R4 set beats write", "R4 bit7 ignored",
    "R10 other offset",     "R10 R8 mask kept",   "R9 timer1 irq",
    "R6 clear all",         "R7 flags kept"
  };

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [3:0] a, input logic [7:0] d,
                      input logic [6:0] s, input logic [6:0] c);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; src_set = s; src_clr = c;
    @(posedge clk);
    #2;
    @(negedge clk);
    reg_wr = 1'b0; src_set = 7'h00; src_clr = 7'h00;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk8("R1 reset rd_data", rd_data, 8'h00);
    chk1("R1 reset irq_n", irq_n, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      reg_wr    = VEC[k][35];
      reg_addr  = VEC[k][34:31];
      reg_wdata = VEC[k][30:23];
      src_set   = VEC[k][22:16];
      src_clr   = VEC[k][15:9];
      @(posedge clk);
      #2;
      chk8(vtag[k], rd_data, VEC[k][8:1]);
      chk1(vtag[k], irq_n, VEC[k][0]);
    end
    @(negedge clk);
    reg_wr = 1'b0; src_set = 7'h00; src_clr = 7'h00;

    // R1: reset while an enabled flag is pending (flags now 0x48)
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd14; reg_wdata = 8'hFF;
    @(posedge clk); #2;
    chk1("R9 pending before reset", irq_n, 1'b0);
    @(negedge clk);
    reg_wr = 1'b0; rst = 1'b1;
    @(posedge clk); #2;
    chk8("R1 mid-run reset rd_data", rd_data, 8'h00);
    chk1("R1 mid-run reset irq_n", irq_n, 1'b1);
    @(negedge clk);
    rst = 1'b0; reg_addr = 4'd13;
    @(posedge clk); #2;
    chk8("R1 flags cleared", rd_data, 8'h00);
    @(negedge clk);
    reg_addr = 4'd14;
    @(posedge clk); #2;
    chk8("R1 R8 enables cleared", rd_data, 8'h80);

    // all sources at once, enabled in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd14; reg_wdata = 8'hFF; src_set = 7'h7F;
    @(posedge clk); #2;
    chk8("R8 R11 full mask", rd_data, 8'hFF);
    chk1("R9 all pending", irq_n, 1'b0);
    @(negedge clk);
    reg_wr = 1'b0; src_set = 7'h00; reg_addr = 4'd13;
    @(posedge clk); #2;
    chk8("R7 all flags", rd_data, 8'hFF);
    step(1'b1, 4'd13, 8'h7F, 7'h00, 7'h00);
    chk8("R4 clear all", rd_data, 8'h00);
    chk1("R9 none pending", irq_n, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule